// File: doc/BRIEF.md
# PHY Management Control Register File

This block is the register bank a PHY exposes to station management. A 5-bit index selects one of 32 register slots over a plain synchronous port: a write is taken on the clock edge where the write enable is high, and read data follows the index combinationally. The serial management framing that would normally drive the port is not part of the block.

Index 0 is the control register. Its bits drive level outputs toward the PHY core: loopback, line rate, autonegotiation enable, power down, isolate, duplex and collision test. Two of its bits are self-clearing commands. One is a port soft reset, which reloads the control defaults and also restarts autonegotiation. The other restarts autonegotiation on its own. The rate, autonegotiation-enable and duplex defaults come from strap pins. The straps are sampled only at a hardware reset or a soft reset.

Indices 20, 22, 30 and 31 are 16-bit scratch and test words. A soft reset does not touch them, so a test setup written there is still in place after the port restarts. Only the hardware reset clears them.

Top module: `phy_mgmt_regs`

## Requirements
- R1: While `rst_n` is low at a clock edge, every register is loaded with its default. Index 0 becomes bit 13 = `strap_speed`, bit 12 = `strap_aneg`, bit 8 = `strap_duplex`, and all other bits 0. Indices 20, 22, 30 and 31 become 0x0000. Both pulse outputs are 0.
- R2: Bits 6:0 of index 0 always read 0. Writing ones to them has no effect.
- R3: A write to index 0 with bits 15 and 9 clear stores the writable bits: 14 loopback, 13 speed (1 = 100 Mb/s), 12 autonegotiation enable, 11 power down, 10 isolate, 8 duplex (1 = full) and 7 collision test. Each matching level output equals its stored bit from the cycle after the write edge.
- R4: Writing index 0 with bit 15 set raises `soft_rst` for exactly one cycle after the write edge. Bit 15 reads 1 in that cycle and 0 afterwards.
- R5: A soft reset loads index 0 with its defaults, taking the strap values present at the write edge. The other data bits of that write are discarded.
- R6: A soft reset leaves indices 20, 22, 30 and 31 unchanged.
- R7: A soft reset also raises `aneg_restart` in the same single cycle as `soft_rst`, and bit 9 reads 1 in that cycle.
- R8: Writing index 0 with bit 9 set and bit 15 clear stores the other writable bits and raises `aneg_restart` for exactly one cycle. Bit 9 reads 1 in that cycle and 0 afterwards.
- R9: A change on the strap inputs outside a hardware or soft reset does not alter any register or level output.
- R10: Every index other than 0, 20, 22, 30 and 31 reads 0x0000. Writes to those indices change nothing.
- R11: Indices 20, 22, 30 and 31 each store and return a full 16-bit value independently.
- R12: Read data reflects register contents before the clock edge. A read in the same cycle as a write returns the pre-write value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low hardware reset |
| strap_speed | input | 1 | Default for the speed bit |
| strap_aneg | input | 1 | Default for the autonegotiation-enable bit |
| strap_duplex | input | 1 | Default for the duplex bit |
| reg_addr | input | 5 | Register index for read and write |
| wr_en | input | 1 | Write strobe, taken at the clock edge |
| wr_data | input | 16 | Write data |
| rd_data | output | 16 | Read data of the indexed register |
| soft_rst | output | 1 | One-cycle port soft-reset pulse |
| aneg_restart | output | 1 | One-cycle autonegotiation restart pulse |
| loopback | output | 1 | Loopback enable level |
| speed_100 | output | 1 | 1 = 100 Mb/s, 0 = 10 Mb/s |
| aneg_en | output | 1 | Autonegotiation enable level |
| power_down | output | 1 | Power-down level |
| isolate | output | 1 | Isolate level |
| full_duplex | output | 1 | 1 = full duplex |
| coll_test | output | 1 | Collision test level |

## Verification
The hardest case to reach from the ports is a soft reset that has to pick up strap values that differ from those latched at hardware reset, while the test words hold non-default data. The stimulus first writes distinctive patterns into the four test words. It then moves the straps and confirms that nothing changes. Finally it issues the soft reset and checks that the control word now shows the new strap values while the test words keep their patterns. The read-during-write ordering is reached by sampling read data in the cycle in which a write is set up, before its clock edge.

// File: rtl/phy_mgmt_pkg.sv
// Package: shared index map and control-word bit positions for the
// PHY management register file.
// Assumes a 16-bit register word and a 5-bit register index.
package phy_mgmt_pkg;
    localparam int ADDR_W = 5;
    localparam int DATA_W = 16;

    localparam int N_KEEP = 4;
    // Indices whose contents survive a soft reset.
    localparam logic [ADDR_W-1:0] KEEP_IDX [N_KEEP] = '{5'd20, 5'd22, 5'd30, 5'd31};
    localparam logic [ADDR_W-1:0] CTRL_IDX = 5'd0;

    // Control-word bit positions (decoded by the PHY core side).
    localparam int B_SRST  = 15;
    localparam int B_LOOP  = 14;
    localparam int B_SPEED = 13;
    localparam int B_ANEN  = 12;
    localparam int B_PDN   = 11;
    localparam int B_ISO   = 10;
    localparam int B_ANRS  = 9;
    localparam int B_DUP   = 8;
    localparam int B_COLL  = 7;
endpackage

// File: rtl/phy_ctrl_reg.sv
// Module: control register (index 0).
// Holds the writable control levels, loads strap-derived defaults on
// hardware and soft reset, and produces the two self-clearing command
// pulses. Assumes wr_sel is already qualified by index and write strobe.
module phy_ctrl_reg
    import phy_mgmt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_sel,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              strap_speed,
    input  logic              strap_aneg,
    input  logic              strap_duplex,
    output logic [DATA_W-1:0] ctrl_word,
    output logic              soft_rst,
    output logic              aneg_restart,
    output logic              loopback,
    output logic              speed_100,
    output logic              aneg_en,
    output logic              power_down,
    output logic              isolate,
    output logic              full_duplex,
    output logic              coll_test
);
    logic loop_q, speed_q, anen_q, pdn_q, iso_q, dup_q, coll_q;
    logic srst_q, anrs_q;
    logic unused_low;

    assign unused_low = ^wr_data[6:0];

    // Register update: hardware reset, soft reset, field write, or pulse clear.
    always_ff @(posedge clk) begin
        if (!rst_n || (wr_sel && wr_data[B_SRST])) begin
            loop_q  <= 1'b0;
            speed_q <= strap_speed;
            anen_q  <= strap_aneg;
            pdn_q   <= 1'b0;
            iso_q   <= 1'b0;
            dup_q   <= strap_duplex;
            coll_q  <= 1'b0;
            srst_q  <= rst_n;
            anrs_q  <= rst_n;
        end else if (wr_sel) begin
            loop_q  <= wr_data[B_LOOP];
            speed_q <= wr_data[B_SPEED];
            anen_q  <= wr_data[B_ANEN];
            pdn_q   <= wr_data[B_PDN];
            iso_q   <= wr_data[B_ISO];
            dup_q   <= wr_data[B_DUP];
            coll_q  <= wr_data[B_COLL];
            srst_q  <= 1'b0;
            anrs_q  <= wr_data[B_ANRS];
        end else begin
            srst_q  <= 1'b0;
            anrs_q  <= 1'b0;
        end
    end

    // Assemble the read-back word; reserved bits read zero.
    always_comb begin
        ctrl_word          = '0;
        ctrl_word[B_SRST]  = srst_q;
        ctrl_word[B_LOOP]  = loop_q;
        ctrl_word[B_SPEED] = speed_q;
        ctrl_word[B_ANEN]  = anen_q;
        ctrl_word[B_PDN]   = pdn_q;
        ctrl_word[B_ISO]   = iso_q;
        ctrl_word[B_ANRS]  = anrs_q;
        ctrl_word[B_DUP]   = dup_q;
        ctrl_word[B_COLL]  = coll_q;
    end

    assign soft_rst     = srst_q;
    assign aneg_restart = anrs_q;
    assign loopback     = loop_q;
    assign speed_100    = speed_q;
    assign aneg_en      = anen_q;
    assign power_down   = pdn_q;
    assign isolate      = iso_q;
    assign full_duplex  = dup_q;
    assign coll_test    = coll_q;

    // R4: soft reset pulse lasts one cycle unless re-commanded.
    p_srst_width_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (soft_rst && !(wr_sel && wr_data[B_SRST])) |=> !soft_rst);
    // R7: soft reset always comes with an autonegotiation restart.
    p_srst_anrs_r7: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |-> aneg_restart);
    // R8: restart pulse lasts one cycle unless re-commanded.
    p_anrs_width_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (aneg_restart && !(wr_sel && (wr_data[B_ANRS] || wr_data[B_SRST]))) |=> !aneg_restart);
    // R5: soft reset takes strap values present at the commanding edge.
    p_srst_strap_r5: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |-> (speed_100 == $past(strap_speed) && aneg_en == $past(strap_aneg)
                      && full_duplex == $past(strap_duplex) && !loopback));
    // R9: without a write, strap pins cannot move the levels.
    p_strap_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_sel |=> ($stable(speed_100) && $stable(aneg_en) && $stable(full_duplex)));
endmodule

// File: rtl/phy_keep_reg.sv
// Module: one 16-bit read/write storage word that is cleared only by
// the hardware reset; soft reset has no path into it.
// Assumes wr_sel is already qualified by index and write strobe.
module phy_keep_reg #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_sel,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] q
);
    // Storage update: clear on hardware reset, load on selected write.
    always_ff @(posedge clk) begin
        if (!rst_n)      q <= '0;
        else if (wr_sel) q <= wr_data;
    end

    // R6 / R10: without its own write the word never changes.
    p_keep_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_sel |=> $stable(q));
endmodule

// File: rtl/phy_mgmt_regs.sv
// Module: top of the PHY management register file.
// Decodes the register index, routes writes to the control register and
// the soft-reset-proof test words, and muxes read data. Read data is
// combinational from register state, so it shows pre-write contents.
module phy_mgmt_regs
    import phy_mgmt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              strap_speed,
    input  logic              strap_aneg,
    input  logic              strap_duplex,
    input  logic [4:0]        reg_addr,
    input  logic              wr_en,
    input  logic [15:0]       wr_data,
    output logic [15:0]       rd_data,
    output logic              soft_rst,
    output logic              aneg_restart,
    output logic              loopback,
    output logic              speed_100,
    output logic              aneg_en,
    output logic              power_down,
    output logic              isolate,
    output logic              full_duplex,
    output logic              coll_test
);
    logic [DATA_W-1:0] ctrl_word;
    logic [DATA_W-1:0] keep_q [N_KEEP];
    logic [N_KEEP-1:0] keep_hit;
    logic              ctrl_wr;

    assign ctrl_wr = wr_en && (reg_addr == CTRL_IDX);

    phy_ctrl_reg u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_sel       (ctrl_wr),
        .wr_data      (wr_data),
        .strap_speed  (strap_speed),
        .strap_aneg   (strap_aneg),
        .strap_duplex (strap_duplex),
        .ctrl_word    (ctrl_word),
        .soft_rst     (soft_rst),
        .aneg_restart (aneg_restart),
        .loopback     (loopback),
        .speed_100    (speed_100),
        .aneg_en      (aneg_en),
        .power_down   (power_down),
        .isolate      (isolate),
        .full_duplex  (full_duplex),
        .coll_test    (coll_test)
    );

    for (genvar g = 0; g < N_KEEP; g++) begin : g_keep
        assign keep_hit[g] = (reg_addr == KEEP_IDX[g]);
        phy_keep_reg #(.DATA_W(DATA_W)) u_word (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_sel  (wr_en && keep_hit[g]),
            .wr_data (wr_data),
            .q       (keep_q[g])
        );
    end

    // Read mux: control word, a test word, or zero for unmapped indices.
    always_comb begin
        rd_data = '0;
        if (reg_addr == CTRL_IDX) rd_data = ctrl_word;
        for (int k = 0; k < N_KEEP; k++)
            if (keep_hit[k]) rd_data = keep_q[k];
    end

    // R10: at most one storage word is ever selected by an index.
    p_one_hit_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(keep_hit));
    // R6: test words hold across the soft reset cycle.
    p_srst_keeps_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (soft_rst && !wr_en) |=> ($stable(keep_q[0]) && $stable(keep_q[3])));
endmodule

// File: tb/phy_mgmt_regs_bench.sv
module phy_mgmt_regs_bench;
    logic clk = 0;
    logic rst_n = 0;
    logic s_spd = 0, s_an = 0, s_dup = 0;
    logic [4:0]  addr = 0;
    logic        we = 0;
    logic [15:0] wd = 0;
    logic [15:0] rd;
    logic srst, anrs, lb, spd, anen, pdn, iso, dup, coll;
    int n_cmp = 0, n_bad = 0, cyc = 0;

    always #4 clk = ~clk;

    phy_mgmt_regs u_phy_mgmt_regs (
        .clk(clk), .rst_n(rst_n), .strap_speed(s_spd), .strap_aneg(s_an),
        .strap_duplex(s_dup), .reg_addr(addr), .wr_en(we), .wr_data(wd),
        .rd_data(rd), .soft_rst(srst), .aneg_restart(anrs), .loopback(lb),
        .speed_100(spd), .aneg_en(anen), .power_down(pdn), .isolate(iso),
        .full_duplex(dup), .coll_test(coll)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] dflt(input logic s, input logic a, input logic d);
        return (16'(s) << 13) | (16'(a) << 12) | (16'(d) << 8);
    endfunction

    // map 7 field bits {loop,speed,anen,pdn,iso,dup,coll} to word positions
    function automatic logic [15:0] fw(input logic [6:0] v);
        return (16'(v[6]) << 14) | (16'(v[5]) << 13) | (16'(v[4]) << 12) |
               (16'(v[3]) << 11) | (16'(v[2]) << 10) | (16'(v[1]) << 8) | (16'(v[0]) << 7);
    endfunction

    function automatic logic [15:0] tpat(input int i, input int k);
        return 16'((i * 16'h1357) ^ (k * 16'h0F0F) ^ 16'hA5C3);
    endfunction

    task automatic wr(input logic [4:0] a, input logic [15:0] d);
        @(negedge clk); addr = a; wd = d; we = 1;
        @(negedge clk); we = 0;
    endtask

    task automatic rdr(input logic [4:0] a, output logic [15:0] v);
        addr = a; #1; v = rd;
    endtask

    task automatic hwrst(input logic s, input logic a, input logic d);
        @(negedge clk); rst_n = 0; s_spd = s; s_an = a; s_dup = d; we = 0;
        @(negedge clk); @(negedge clk); rst_n = 1;
    endtask

    task automatic summary;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog actual=%0d expected=<150000", cyc);
            summary();
        end
    end

    localparam logic [4:0] KI [4] = '{5'd20, 5'd22, 5'd30, 5'd31};

    initial begin
        logic [15:0] v, old;
        // R1: reset defaults under every strap combination
        for (int s = 0; s < 8; s++) begin
            wr(5'd20, 16'hFFFF);
            hwrst(s[2], s[1], s[0]);
            rdr(5'd0, v);  chk("R1 ctrl default", v, dflt(s[2], s[1], s[0]));
            rdr(5'd20, v); chk("R1 test word cleared", v, 16'h0000);
            chk("R1 pulses low", {14'd0, srst, anrs}, 16'h0);
            chk("R1 levels", {9'd0, lb, spd, anen, pdn, iso, dup, coll},
                {9'd0, 1'b0, s[2], s[1], 2'b00, s[0], 1'b0});
        end
        // R2, R3: sweep every writable field combination, reserved bits set
        for (int f = 0; f < 128; f++) begin
            wr(5'd0, fw(7'(f)) | 16'h007F);
            rdr(5'd0, v);
            chk("R2 R3 readback", v, fw(7'(f)));
            chk("R3 levels", {9'd0, lb, spd, anen, pdn, iso, dup, coll}, 16'(f));
            chk("R8 no stray pulse", {14'd0, srst, anrs}, 16'h0);
        end
        // R12: read during write returns old value
        wr(5'd0, fw(7'h15));
        @(negedge clk); addr = 0; wd = fw(7'h6A); we = 1; #1;
        chk("R12 pre-write read", rd, fw(7'h15));
        @(negedge clk); we = 0; #1;
        chk("R12 post-write read", rd, fw(7'h6A));
        // R8: autonegotiation restart pulse
        wr(5'd0, fw(7'h22) | 16'h0200);
        rdr(5'd0, v);
        chk("R8 bit9 during pulse", v, fw(7'h22) | 16'h0200);
        chk("R8 pulse", {14'd0, srst, anrs}, 16'h1);
        @(negedge clk); rdr(5'd0, v);
        chk("R8 bit9 cleared", v, fw(7'h22));
        chk("R8 pulse ended", {14'd0, srst, anrs}, 16'h0);
        // R11: test words
        for (int i = 0; i < 4; i++) wr(KI[i], tpat(i, 1));
        for (int i = 0; i < 4; i++) begin
            rdr(KI[i], v); chk("R11 test word", v, tpat(i, 1));
        end
        // R10: unmapped indices read zero and writes change nothing
        wr(5'd0, fw(7'h4C));
        for (int a = 0; a < 32; a++) begin
            if (a == 0 || a == 20 || a == 22 || a == 30 || a == 31) continue;
            wr(5'(a), 16'hFFFF);
            rdr(5'(a), v); chk("R10 unmapped zero", v, 16'h0);
        end
        rdr(5'd0, v); chk("R10 ctrl untouched", v, fw(7'h4C));
        for (int i = 0; i < 4; i++) begin
            rdr(KI[i], v); chk("R10 test word untouched", v, tpat(i, 1));
        end
        // R9: straps move, nothing changes
        hwrst(1'b0, 1'b0, 1'b0);
        for (int i = 0; i < 4; i++) wr(KI[i], tpat(i, 2));
        @(negedge clk); s_spd = 1; s_an = 1; s_dup = 1;
        repeat (3) @(negedge clk);
        rdr(5'd0, v); chk("R9 straps ignored", v, dflt(0, 0, 0));
        chk("R9 levels", {13'd0, spd, anen, dup}, 16'h0);
        // R4 R5 R6 R7: soft reset with new straps and junk data bits
        wr(5'd0, fw(7'h7F) | 16'h8000);
        rdr(5'd0, v);
        chk("R4 R7 word in pulse", v, dflt(1, 1, 1) | 16'h8200);
        chk("R4 R7 pulses", {14'd0, srst, anrs}, 16'h3);
        @(negedge clk); rdr(5'd0, v);
        chk("R4 R5 after pulse", v, dflt(1, 1, 1));
        chk("R4 pulses ended", {14'd0, srst, anrs}, 16'h0);
        chk("R5 levels", {9'd0, lb, spd, anen, pdn, iso, dup, coll}, 16'h32);
        for (int i = 0; i < 4; i++) begin
            rdr(KI[i], v); chk("R6 kept across soft reset", v, tpat(i, 2));
        end
        // R5: soft reset with straps low, after fields changed
        s_spd = 0; s_an = 1; s_dup = 0;
        wr(5'd0, fw(7'h5A));
        wr(5'd0, 16'h8000);
        @(negedge clk); rdr(5'd0, old);
        chk("R5 second soft reset", old, dflt(0, 1, 0));
        summary();
    end
endmodule